// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A sixteen-state controller, clocked by the test clock and steered by the mode-select pin, sequences instruction scans and data scans. Instructions are shifted into a holding register from the serial input and take effect only when the scan is committed. The active instruction then chooses which data register sits between the serial input and the serial output: a one-bit bypass stage, a device-identification register, or an external boundary register. The boundary cells are not part of this block. They are reached through capture, shift and update strobes, a select line and a serial return input.

The serial output is retimed on the falling edge of the test clock. Its enable is raised only while a shift state is active. An active-low asynchronous port reset, or five rising clock edges with the mode pin high, puts the controller into its reset state and restores the default instruction.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `trst_n` is low the controller is held in its reset state (`tap_reset` high, `tdo_en` low) without waiting for a clock. On leaving reset the active instruction is IDCODE, so a data scan returns the 32-bit identification value, least significant bit first. If the identification register is disabled by parameter, the default instruction is BYPASS instead.
- R2: Five consecutive rising edges of `tck` with `tms` high bring the controller to the reset state from any state, and this restores the default instruction. Four such edges starting from Shift-DR do not reach the reset state.
- R3: Each instruction scan captures the value 4'b0001 into the 4-bit shift stage, which reaches `tdo` least significant bit first. The new code is shifted in from `tdi`, also least significant bit first.
- R4: A shifted instruction becomes active on the rising edge that leaves Update-IR. While the controller is in Update-IR, the decode outputs still reflect the previous instruction.
- R5: Instruction code 4'b0011 (IDCODE) selects the identification register. Capture-DR loads the register with the identification value, whose bit 0 is 1, and Shift-DR moves it out least significant bit first.
- R6: Instruction code 4'b1111 (BYPASS) places a single stage between `tdi` and `tdo`. Capture-DR loads 0 into that stage, so a scan returns 0 followed by the input bits delayed by one clock.
- R7: Any code other than 4'b0000, 4'b0001, 4'b0010, 4'b0011 and 4'b0100 behaves as BYPASS.
- R8: Codes 4'b0000 (EXTEST), 4'b0001 (SAMPLE), 4'b0010 (PRELOAD) and 4'b0100 (INTEST) raise `bsr_sel`, and during Shift-DR `tdo` then follows `bsr_so`. `ext_drive` is high only under EXTEST. `int_drive` is high only under INTEST.
- R9: `dr_capture`, `dr_shift` and `dr_update` are high exactly in Capture-DR, Shift-DR and Update-DR. The `ir_` strobes are high exactly in the matching IR states. At most one strobe, or `tap_reset`, is high at a time. `ir_path_sel` is high throughout the instruction-scan branch.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR.
- R11: In Pause-DR the selected register holds its contents and `tdo_en` is low. Returning to Shift-DR through Exit2-DR continues the scan with the next bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial return from the external boundary register |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_en | output | 1 | Output-driver enable for `tdo` |
| tap_reset | output | 1 | High in the reset state |
| ir_path_sel | output | 1 | High when the instruction branch is active |
| ir_capture | output | 1 | Capture-IR strobe |
| ir_shift | output | 1 | Shift-IR strobe |
| ir_update | output | 1 | Update-IR strobe |
| dr_capture | output | 1 | Capture-DR strobe |
| dr_shift | output | 1 | Shift-DR strobe |
| dr_update | output | 1 | Update-DR strobe |
| bsr_sel | output | 1 | Boundary register is the selected data register |
| ext_drive | output | 1 | Boundary outputs drive the pins (EXTEST) |
| int_drive | output | 1 | Boundary inputs drive the core (INTEST) |

## Verification
The state strobes are valid for the whole clock period that follows the rising edge on which a state is entered. Serial output and its enable follow half a period later, on the falling edge. A new instruction's decode appears one rising edge after Update-IR. The bench therefore drives `tms` and `tdi` just after a falling edge and reads every output 1 ns after the next falling edge. The only exception is a dedicated check that samples just after the rising edge, to show that `tdo_en` has not yet moved. Scan results are collected one bit per clock: before each shifting edge the bench reads the bit presented at the preceding falling edge, and it compares the bits with values it derives from the requirement codes.

// File: rtl/scan_tap_pkg.sv
// Shared types and instruction codes of the scan test port.
// Assumes a 4-bit instruction register; wider registers zero-extend the codes.
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_st_e;

    typedef enum logic [1:0] {
        DSEL_BYPASS = 2'd0,
        DSEL_ID     = 2'd1,
        DSEL_BSR    = 2'd2
    } dr_sel_e;

    typedef struct packed {
        logic in_reset;
        logic ir_branch;
        logic ir_cap;
        logic ir_sh;
        logic ir_upd;
        logic dr_cap;
        logic dr_sh;
        logic dr_upd;
    } tap_ctl_t;

    localparam logic [3:0] OPC_EXTEST  = 4'b0000;
    localparam logic [3:0] OPC_SAMPLE  = 4'b0001;
    localparam logic [3:0] OPC_PRELOAD = 4'b0010;
    localparam logic [3:0] OPC_IDCODE  = 4'b0011;
    localparam logic [3:0] OPC_INTEST  = 4'b0100;

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state port controller. Steered only by tms on the rising edge of tck.
// Assumes trst_n is asynchronous and active low; outputs are decoded from the state.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tms,
    output tap_ctl_t ctl
);

    tap_st_e state_q, state_d;

    // Next-state selection from the current state and tms.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register with asynchronous port reset.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    // Strobe decode from the present state.
    always_comb begin
        ctl           = '0;
        ctl.in_reset  = (state_q == ST_RESET);
        ctl.ir_branch = (state_q inside {ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR,
                                         ST_PAU_IR, ST_EX2_IR, ST_UPD_IR});
        ctl.ir_cap    = (state_q == ST_CAP_IR);
        ctl.ir_sh     = (state_q == ST_SH_IR);
        ctl.ir_upd    = (state_q == ST_UPD_IR);
        ctl.dr_cap    = (state_q == ST_CAP_DR);
        ctl.dr_sh     = (state_q == ST_SH_DR);
        ctl.dr_upd    = (state_q == ST_UPD_DR);
    end

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction shift stage, active instruction and decode.
// Assumes IR_W >= 4; codes outside the supported set decode to bypass.
module scan_tap_ir
    import scan_tap_pkg::*;
#(
    parameter int IR_W   = 4,
    parameter bit HAS_ID = 1'b1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_ctl_t        ctl,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_active,
    output dr_sel_e         dr_sel,
    output logic            ext_drive,
    output logic            int_drive
);

    localparam logic [IR_W-1:0] C_EXTEST  = IR_W'(OPC_EXTEST);
    localparam logic [IR_W-1:0] C_SAMPLE  = IR_W'(OPC_SAMPLE);
    localparam logic [IR_W-1:0] C_PRELOAD = IR_W'(OPC_PRELOAD);
    localparam logic [IR_W-1:0] C_IDCODE  = IR_W'(OPC_IDCODE);
    localparam logic [IR_W-1:0] C_INTEST  = IR_W'(OPC_INTEST);
    localparam logic [IR_W-1:0] C_BYPASS  = {IR_W{1'b1}};
    localparam logic [IR_W-1:0] C_DEFAULT = HAS_ID ? C_IDCODE : C_BYPASS;
    localparam logic [IR_W-1:0] C_CAPTURE = IR_W'(2'b01);

    logic [IR_W-1:0] sr_q;

    // Shift stage: fixed capture pattern, then LSB-first shifting.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)         sr_q <= '0;
        else if (ctl.ir_cap) sr_q <= C_CAPTURE;
        else if (ctl.ir_sh)  sr_q <= {tdi, sr_q[IR_W-1:1]};
    end

    // Active instruction: default on reset, commit on Update-IR.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)           ir_active <= C_DEFAULT;
        else if (ctl.in_reset) ir_active <= C_DEFAULT;
        else if (ctl.ir_upd)   ir_active <= sr_q;
    end

    assign ir_so = sr_q[0];

    // Decode of the active instruction into register select and drive modes.
    always_comb begin
        dr_sel    = DSEL_BYPASS;
        ext_drive = 1'b0;
        int_drive = 1'b0;
        case (ir_active)
            C_EXTEST: begin
                dr_sel    = DSEL_BSR;
                ext_drive = 1'b1;
            end
            C_SAMPLE, C_PRELOAD: dr_sel = DSEL_BSR;
            C_INTEST: begin
                dr_sel    = DSEL_BSR;
                int_drive = 1'b1;
            end
            C_IDCODE: dr_sel = HAS_ID ? DSEL_ID : DSEL_BYPASS;
            default:  dr_sel = DSEL_BYPASS;
        endcase
    end

endmodule

// File: rtl/scan_tap_dr.sv
// Internal data registers (bypass stage and optional identification register)
// and the data-side serial return mux. The boundary register lies outside.
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int             ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h4A3C_5E1D,
    parameter bit             HAS_ID = 1'b1
) (
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  tap_ctl_t ctl,
    input  dr_sel_e  dr_sel,
    input  logic     bsr_so,
    output logic     dr_so
);

    logic byp_q;
    logic id_so;

    // One-stage bypass: clears on capture, follows tdi while shifting.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                                    byp_q <= 1'b0;
        else if (ctl.dr_cap && dr_sel == DSEL_BYPASS)   byp_q <= 1'b0;
        else if (ctl.dr_sh && dr_sel == DSEL_BYPASS)    byp_q <= tdi;
    end

    generate
        if (HAS_ID) begin : g_id
            logic [ID_W-1:0] id_q;
            // Identification register: load the fixed value, shift LSB first.
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n)                              id_q <= '0;
                else if (ctl.dr_cap && dr_sel == DSEL_ID) id_q <= ID_VAL;
                else if (ctl.dr_sh && dr_sel == DSEL_ID)  id_q <= {tdi, id_q[ID_W-1:1]};
            end
            assign id_so = id_q[0];
        end else begin : g_no_id
            assign id_so = 1'b0;
        end
    endgenerate

    // Serial return from whichever data register is selected.
    always_comb begin
        case (dr_sel)
            DSEL_ID:  dr_so = id_so;
            DSEL_BSR: dr_so = bsr_so;
            default:  dr_so = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_tap_ctrl.sv
// Top of the scan test port. Joins the controller, the instruction path and the
// data registers, and retimes the serial output on the falling edge of tck.
// Assumes tms and tdi are stable around the rising edge of tck.
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int              IR_W   = 4,
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h4A3C_5E1D,
    parameter bit              HAS_ID = 1'b1
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic bsr_so,
    output logic tdo,
    output logic tdo_en,
    output logic tap_reset,
    output logic ir_path_sel,
    output logic ir_capture,
    output logic ir_shift,
    output logic ir_update,
    output logic dr_capture,
    output logic dr_shift,
    output logic dr_update,
    output logic bsr_sel,
    output logic ext_drive,
    output logic int_drive
);

    tap_ctl_t        ctl;
    dr_sel_e         dr_sel;
    logic            ir_so;
    logic            dr_so;
    logic [IR_W-1:0] cur_instr;
    logic            shifting;

    scan_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .ctl    (ctl)
    );

    scan_tap_ir #(.IR_W(IR_W), .HAS_ID(HAS_ID)) u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .ctl       (ctl),
        .ir_so     (ir_so),
        .ir_active (cur_instr),
        .dr_sel    (dr_sel),
        .ext_drive (ext_drive),
        .int_drive (int_drive)
    );

    scan_tap_dr #(.ID_W(ID_W), .ID_VAL(ID_VAL), .HAS_ID(HAS_ID)) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .ctl    (ctl),
        .dr_sel (dr_sel),
        .bsr_so (bsr_so),
        .dr_so  (dr_so)
    );

    assign shifting = ctl.ir_sh | ctl.dr_sh;

    // Falling-edge retiming of serial data and driver enable.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= shifting ? (ctl.ir_sh ? ir_so : dr_so) : 1'b0;
            tdo_en <= shifting;
        end
    end

    assign tap_reset   = ctl.in_reset;
    assign ir_path_sel = ctl.ir_branch;
    assign ir_capture  = ctl.ir_cap;
    assign ir_shift    = ctl.ir_sh;
    assign ir_update   = ctl.ir_upd;
    assign dr_capture  = ctl.dr_cap;
    assign dr_shift    = ctl.dr_sh;
    assign dr_update   = ctl.dr_upd;
    assign bsr_sel     = (dr_sel == DSEL_BSR);

endmodule

// File: rtl/scan_tap_chk.sv
// Property checker for the scan test port, bound to the top module.
module scan_tap_chk #(
    parameter int IR_W = 4
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            tdo_en,
    input logic            tap_reset,
    input logic            ir_path_sel,
    input logic            ir_capture,
    input logic            ir_shift,
    input logic            ir_update,
    input logic            dr_capture,
    input logic            dr_shift,
    input logic            dr_update,
    input logic            bsr_sel,
    input logic            ext_drive,
    input logic            int_drive,
    input logic [IR_W-1:0] cur_instr
);

    logic [2:0] hi_cnt;

    // Counts consecutive rising edges with tms high, saturating at five.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)            hi_cnt <= 3'd0;
        else if (!tms)          hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    a_r2_five_high_resets: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_cnt == 3'd5) |-> tap_reset);

    a_r10_enable_only_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (ir_shift || dr_shift));

    a_r9_one_strobe: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({tap_reset, ir_capture, ir_shift, ir_update,
                  dr_capture, dr_shift, dr_update}));

    a_r9_ir_update_single: assert property (@(posedge tck) disable iff (!trst_n)
        ir_update |=> !ir_update);

    a_r9_dr_update_single: assert property (@(posedge tck) disable iff (!trst_n)
        dr_update |=> !dr_update);

    a_r9_ir_shift_in_branch: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_capture || ir_shift || ir_update) |-> ir_path_sel);

    a_r4_commit_on_update: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(cur_instr) |-> ($past(ir_update) || $past(tap_reset)));

    a_r8_drive_modes: assert property (@(posedge tck) disable iff (!trst_n)
        (ext_drive || int_drive) |-> (bsr_sel && !(ext_drive && int_drive)));

endmodule

bind scan_tap_ctrl scan_tap_chk #(.IR_W(IR_W)) u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .tdo_en      (tdo_en),
    .tap_reset   (tap_reset),
    .ir_path_sel (ir_path_sel),
    .ir_capture  (ir_capture),
    .ir_shift    (ir_shift),
    .ir_update   (ir_update),
    .dr_capture  (dr_capture),
    .dr_shift    (dr_shift),
    .dr_update   (dr_update),
    .bsr_sel     (bsr_sel),
    .ext_drive   (ext_drive),
    .int_drive   (int_drive),
    .cur_instr   (cur_instr)
);

// File: tb/scan_tap_ctrl_tb_top.sv
// Self-checking bench: a vector table of instructions walked by one loop,
// then directed tests for reset, pause, edge timing and strobe ordering.
module scan_tap_ctrl_tb_top;

    localparam logic [31:0] ID = 32'h4A3C_5E1D;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic bsr_so = 1'b0;
    logic tdo, tdo_en, tap_reset, ir_path_sel, ir_capture, ir_shift, ir_update;
    logic dr_capture, dr_shift, dr_update, bsr_sel, ext_drive, int_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 tck = ~tck;

    scan_tap_ctrl dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
        .tdo(tdo), .tdo_en(tdo_en), .tap_reset(tap_reset), .ir_path_sel(ir_path_sel),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .bsr_sel(bsr_sel), .ext_drive(ext_drive), .int_drive(int_drive)
    );

    // Vector: code[7:4], kind[3:2] (0 boundary, 1 id, 2 bypass), ext[1], int[0]
    localparam logic [7:0] VEC [8] = '{
        {4'b0000, 2'd0, 1'b1, 1'b0},
        {4'b0001, 2'd0, 1'b0, 1'b0},
        {4'b0010, 2'd0, 1'b0, 1'b0},
        {4'b0011, 2'd1, 1'b0, 1'b0},
        {4'b0100, 2'd0, 1'b0, 1'b1},
        {4'b1111, 2'd2, 1'b0, 1'b0},
        {4'b0101, 2'd2, 1'b0, 1'b0},
        {4'b1010, 2'd2, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive inputs, take one rising edge, settle just past the falling edge.
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // From Run-Test/Idle: scan an instruction, return what was captured.
    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        tick(1, 0);
        tick(1, 0);
        tick(0, 0);
        chk("R9 ir_capture", ir_capture, 1);
        tick(0, 0);
        chk("R9 ir_path_sel", ir_path_sel, 1);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            tick(i == 3, code[i]);
        end
        tick(1, 0);
        chk("R9 ir_update", ir_update, 1);
        tick(0, 0);
    endtask

    // From Run-Test/Idle: scan n data bits, return the serial output bits.
    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        tick(1, 0);
        tick(0, 0);
        chk("R9 dr_capture", dr_capture, 1);
        tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0);
        chk("R9 dr_update", dr_update, 1);
        tick(0, 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            errors++;
            $display("FAIL run timeout (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0]  cap;
        logic [31:0] dout;
        logic [31:0] exp;
        logic [7:0]  din;

        // R1: reset state before any clock
        #1;
        chk("R1 tap_reset in reset", tap_reset, 1);
        chk("R1 tdo_en in reset", tdo_en, 0);
        repeat (2) @(negedge tck);
        #1;
        trst_n = 1'b1;
        tick(0, 0);
        scan_dr(32, 32'h0, dout);
        chk("R1 default IDCODE scan", dout, ID);

        // Vector table walk over instruction codes (R3 R5 R6 R7 R8)
        for (int v = 0; v < 8; v++) begin
            scan_ir(VEC[v][7:4], cap);
            chk("R3 captured IR pattern", cap, 4'b0001);
            chk("R8 bsr_sel", bsr_sel, VEC[v][3:2] == 2'd0);
            chk("R8 ext_drive", ext_drive, VEC[v][1]);
            chk("R8 int_drive", int_drive, VEC[v][0]);
            bsr_so = v[0];
            din = 8'hB5 ^ 8'(v * 37);
            scan_dr(8, 32'(din), dout);
            case (VEC[v][3:2])
                2'd0:    begin exp = {24'h0, {8{bsr_so}}}; chk("R8 boundary return", dout, exp); end
                2'd1:    begin exp = {24'h0, ID[7:0]};     chk("R5 id scan", dout, exp); end
                default: begin
                    exp = {24'h0, din[6:0], 1'b0};
                    if (VEC[v][7:4] == 4'b1111) chk("R6 bypass delay", dout, exp);
                    else                        chk("R7 unknown as bypass", dout, exp);
                end
            endcase
        end
        bsr_so = 1'b0;

        // R4: decode unchanged in Update-IR (BYPASS active, EXTEST being loaded)
        tick(1, 0);
        tick(1, 0);
        tick(0, 0);
        tick(0, 0);
        for (int i = 0; i < 4; i++) tick(i == 3, 1'b0);
        tick(1, 0);
        chk("R4 ext_drive held in Update-IR", ext_drive, 0);
        tick(0, 0);
        chk("R4 ext_drive after commit", ext_drive, 1);

        // R2: five high edges from Shift-DR; four do not reset
        scan_ir(4'b1111, cap);
        tick(1, 0);
        tick(0, 0);
        tick(0, 0);
        for (int i = 0; i < 4; i++) tick(1, 0);
        chk("R2 four edges not reset", tap_reset, 0);
        tick(1, 0);
        chk("R2 fifth edge resets", tap_reset, 1);
        tick(0, 0);
        scan_dr(32, 32'h0, dout);
        chk("R2 default instruction restored", dout, ID);

        // R11: pause in the middle of an id scan
        dout = '0;
        tick(1, 0);
        tick(0, 0);
        tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            dout[i] = tdo;
            tick(i == 2, 0);
        end
        tick(0, 0);
        chk("R11 tdo_en low in pause", tdo_en, 0);
        repeat (3) tick(0, 0);
        tick(1, 0);
        tick(0, 0);
        for (int i = 3; i < 8; i++) begin
            dout[i] = tdo;
            tick(i == 7, 0);
        end
        tick(1, 0);
        tick(0, 0);
        chk("R11 scan resumes after pause", dout[7:0], ID[7:0]);

        // R10: tdo_en moves on the falling edge, not the rising edge
        tick(1, 0);
        tick(0, 0);
        tms = 1'b0;
        @(posedge tck);
        #1;
        chk("R10 tdo_en before falling edge", tdo_en, 0);
        @(negedge tck);
        #1;
        chk("R10 tdo_en after falling edge", tdo_en, 1);
        chk("R10 tdo first bit", tdo, ID[0]);
        tick(1, 0);
        chk("R10 tdo_en low in Exit1-DR", tdo_en, 0);
        tick(1, 0);
        tick(0, 0);

        // R1: asynchronous reset in the middle of a scan
        scan_ir(4'b1111, cap);
        tick(1, 0);
        tick(0, 0);
        tick(0, 0);
        #1;
        trst_n = 1'b0;
        #1;
        chk("R1 async tap_reset", tap_reset, 1);
        chk("R1 async tdo_en", tdo_en, 0);
        @(negedge tck);
        #1;
        trst_n = 1'b1;
        tick(0, 0);
        scan_dr(32, 32'h0, dout);
        chk("R1 IDCODE after async reset", dout, ID);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule